// File: doc/BRIEF.md
# HDLC Receive Interrupt Condition Generator

This block decides when an HDLC receiver raises its receive-data interrupt. It watches a one-cycle strobe that marks each byte entering the receive queue, along with the queue's current occupancy. It keeps a sticky interrupt flag that software acknowledges by writing a one to a clear strobe. The queue storage and the HDLC framing live elsewhere.

There are two policies, and a single mode input selects between them.

- **First-character policy.** The block raises the flag once, on the first byte that arrives while detection is armed. Detection is armed after a hardware reset, after a software reset, or after a write to a re-arm command bit. Once the flag has been raised, detection stays disarmed until one of those events occurs again.
- **Threshold policy.** The block raises the flag when the queue count goes from not exceeding a 3-bit threshold to exceeding it. If the count still exceeds the threshold when software clears the flag, the flag is raised again.

The first-character policy uses a state machine with two states:

- `FC_ARMED`: entered by hardware reset, by `sw_reset`, or from `FC_SPENT` by `rearm_wr`. It leaves this state on a byte in first-character mode (the transition "fire") and goes to `FC_SPENT`.
- `FC_SPENT`: left only by `rearm_wr` (the transition "re-arm") or by `sw_reset`.

The threshold policy uses a state machine with three states:

- `TH_BELOW`: the count does not exceed the threshold. When it does ("cross"), the machine goes to `TH_ABOVE`.
- `TH_ABOVE`: the count exceeds the threshold. The machine goes back to `TH_BELOW` when the count drops ("fall"). A clear while the count is still above the threshold goes to `TH_REARM` ("retry").
- `TH_REARM`: the machine goes to `TH_ABOVE` and raises the flag again ("refire"), or goes to `TH_BELOW` if the count has dropped.

The flag itself is a state machine with two states, `FL_IDLE` and `FL_PENDING`. It takes "set" to `FL_PENDING` and "ack" back to `FL_IDLE`.

Top module: `hdlc_rx_irq_gen`

## Requirements
- R1: After hardware reset `irq` is 0 and first-character detection is armed, so the first byte in first-character mode (`mode_sel`=0) raises `irq`.
- R2: In first-character mode, a `byte_rx` strobe while armed makes `irq` 1 from the next clock edge.
- R3: After the first-character interrupt fires, further `byte_rx` strobes do not raise `irq` until detection is re-armed.
- R4: A `rearm_wr` strobe arms detection, so a later byte raises `irq`. A byte that arrives in the same cycle as `rearm_wr` while disarmed does not raise `irq`.
- R5: A `sw_reset` strobe has priority over every other input. From the next edge it makes `irq` 0 and arms first-character detection, and it puts the threshold machine in its below state.
- R6: In threshold mode (`mode_sel`=1), `irq` becomes 1 on the edge after `q_count` first exceeds `thresh` (unsigned, strictly greater). A count equal to the threshold does not raise `irq`.
- R7: In threshold mode, if `irq_clr` clears the flag while `q_count` still exceeds `thresh`, then `irq` is 0 for one cycle and 1 again from the following edge.
- R8: `irq` holds its value until `irq_clr` is applied. A clear with no set pending makes `irq` 0 from the next edge.
- R9: If a set condition and `irq_clr` fall in the same cycle, the set wins and `irq` stays 1.
- R10: Bytes in threshold mode neither raise `irq` nor consume the armed state. Threshold crossings in first-character mode do not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_reset | input | 1 | Software reset strobe |
| mode_sel | input | 1 | 0 = first-character policy, 1 = threshold policy |
| thresh | input | 3 | Queue threshold |
| byte_rx | input | 1 | One-cycle strobe per byte entering the queue |
| q_count | input | CNT_W (4) | Current receive queue occupancy |
| rearm_wr | input | 1 | Write strobe of the re-arm command bit |
| irq_clr | input | 1 | Write-1 acknowledge strobe for the flag |
| irq | output | 1 | Sticky receive interrupt flag |

## Verification
The acknowledge strobe can land in the same cycle as either set source: the first byte after arming, or the count's first step above the threshold. The bench arranges exactly these coincidences by driving `irq_clr` together with `byte_rx` on an armed block, and together with a count step across the threshold. The set must win in both cases, so `irq` must read 1 after that edge, and a later lone clear must bring it to 0. The bench also applies `sw_reset` together with a byte and together with `rearm_wr`, and expects the reset to dominate in both cases.

// File: rtl/hdlc_rx_irq_pkg.sv
package hdlc_rx_irq_pkg;

    typedef enum logic {
        MODE_FIRST  = 1'b0,
        MODE_THRESH = 1'b1
    } rx_irq_mode_e;

    typedef enum logic {
        FC_ARMED = 1'b0,
        FC_SPENT = 1'b1
    } fc_state_e;

    typedef enum logic [1:0] {
        TH_BELOW = 2'd0,
        TH_ABOVE = 2'd1,
        TH_REARM = 2'd2
    } th_state_e;

    typedef enum logic {
        FL_IDLE    = 1'b0,
        FL_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/hdlc_rx_irq_fc_fsm.sv
// One-shot first-character detector.
module hdlc_rx_irq_fc_fsm
    import hdlc_rx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    input  logic mode_first,
    input  logic byte_rx,
    input  logic rearm_wr,
    output logic set_fc
);

    fc_state_e cur_q, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= FC_ARMED;
        end else begin
            cur_q <= nxt;
        end
    end

    // transitions: fire, re-arm
    always_comb begin
        nxt = cur_q;
        if (sw_reset) begin
            nxt = FC_ARMED;
        end else begin
            unique case (cur_q)
                FC_ARMED: begin
                    if (byte_rx && mode_first && !rearm_wr) begin
                        nxt = FC_SPENT;
                    end
                end
                FC_SPENT: begin
                    if (rearm_wr) begin
                        nxt = FC_ARMED;
                    end
                end
                default: nxt = FC_ARMED;
            endcase
        end
    end

    // outputs
    always_comb begin
        set_fc = 1'b0;
        unique case (cur_q)
            FC_ARMED: set_fc = byte_rx && mode_first && !sw_reset;
            FC_SPENT: set_fc = 1'b0;
            default:  set_fc = 1'b0;
        endcase
    end

endmodule

// File: rtl/hdlc_rx_irq_th_fsm.sv
// Threshold crossing detector with retry after acknowledge.
module hdlc_rx_irq_th_fsm
    import hdlc_rx_irq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int TH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             mode_thresh,
    input  logic [CNT_W-1:0] q_count,
    input  logic [TH_W-1:0]  thresh,
    input  logic             irq_clr,
    output logic             set_th
);

    th_state_e cur_q, nxt;
    logic      over;

    assign over = q_count > CNT_W'(thresh);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= TH_BELOW;
        end else begin
            cur_q <= nxt;
        end
    end

    // transitions: cross, fall, retry, refire
    always_comb begin
        nxt = cur_q;
        if (sw_reset) begin
            nxt = TH_BELOW;
        end else begin
            unique case (cur_q)
                TH_BELOW: if (over) nxt = TH_ABOVE;
                TH_ABOVE: begin
                    if (!over) begin
                        nxt = TH_BELOW;
                    end else if (irq_clr) begin
                        nxt = TH_REARM;
                    end
                end
                TH_REARM: nxt = over ? TH_ABOVE : TH_BELOW;
                default:  nxt = TH_BELOW;
            endcase
        end
    end

    // outputs
    always_comb begin
        set_th = 1'b0;
        if (!sw_reset && mode_thresh) begin
            unique case (cur_q)
                TH_BELOW: set_th = over;
                TH_ABOVE: set_th = 1'b0;
                TH_REARM: set_th = over;
                default:  set_th = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_rx_irq_flag.sv
// Sticky flag; set wins over acknowledge, software reset wins over both.
module hdlc_rx_irq_flag
    import hdlc_rx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    input  logic set_req,
    input  logic irq_clr,
    output logic irq
);

    flag_state_e cur_q, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= FL_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    // transitions: set, ack
    always_comb begin
        nxt = cur_q;
        if (sw_reset) begin
            nxt = FL_IDLE;
        end else begin
            unique case (cur_q)
                FL_IDLE:    if (set_req) nxt = FL_PENDING;
                FL_PENDING: if (irq_clr && !set_req) nxt = FL_IDLE;
                default:    nxt = FL_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (cur_q)
            FL_IDLE:    irq = 1'b0;
            FL_PENDING: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/hdlc_rx_irq_gen.sv
module hdlc_rx_irq_gen
    import hdlc_rx_irq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int TH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             mode_sel,
    input  logic [TH_W-1:0]  thresh,
    input  logic             byte_rx,
    input  logic [CNT_W-1:0] q_count,
    input  logic             rearm_wr,
    input  logic             irq_clr,
    output logic             irq
);

    logic mode_first;
    logic mode_thresh;
    logic set_fc;
    logic set_th;

    assign mode_first  = (rx_irq_mode_e'(mode_sel) == MODE_FIRST);
    assign mode_thresh = (rx_irq_mode_e'(mode_sel) == MODE_THRESH);

    hdlc_rx_irq_fc_fsm u_fc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_reset   (sw_reset),
        .mode_first (mode_first),
        .byte_rx    (byte_rx),
        .rearm_wr   (rearm_wr),
        .set_fc     (set_fc)
    );

    hdlc_rx_irq_th_fsm #(
        .CNT_W (CNT_W),
        .TH_W  (TH_W)
    ) u_th (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset    (sw_reset),
        .mode_thresh (mode_thresh),
        .q_count     (q_count),
        .thresh      (thresh),
        .irq_clr     (irq_clr),
        .set_th      (set_th)
    );

    hdlc_rx_irq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_reset (sw_reset),
        .set_req  (set_fc | set_th),
        .irq_clr  (irq_clr),
        .irq      (irq)
    );

endmodule

// File: rtl/hdlc_rx_irq_gen_chk.sv
module hdlc_rx_irq_gen_chk #(
    parameter int CNT_W = 4,
    parameter int TH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_reset,
    input logic             mode_sel,
    input logic [TH_W-1:0]  thresh,
    input logic [CNT_W-1:0] q_count,
    input logic             rearm_wr,
    input logic             irq_clr,
    input logic             set_fc,
    input logic             set_th,
    input logic             irq
);

    assert_swreset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> !irq);

    assert_set_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fc || set_th) && !sw_reset |=> irq);

    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !sw_reset && !set_fc && !set_th |=> !irq);

    assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr && !sw_reset |=> irq);

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !set_fc && !set_th |=> !irq);

    assert_one_shot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_fc && !rearm_wr && !sw_reset |=> !set_fc);

    assert_thresh_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_th |-> (q_count > CNT_W'(thresh)) && mode_sel);

    assert_fc_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_fc |-> !mode_sel);

endmodule

bind hdlc_rx_irq_gen hdlc_rx_irq_gen_chk #(
    .CNT_W (CNT_W),
    .TH_W  (TH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_reset (sw_reset),
    .mode_sel (mode_sel),
    .thresh   (thresh),
    .q_count  (q_count),
    .rearm_wr (rearm_wr),
    .irq_clr  (irq_clr),
    .set_fc   (set_fc),
    .set_th   (set_th),
    .irq      (irq)
);

// File: tb/hdlc_rx_irq_gen_bench.sv
module hdlc_rx_irq_gen_bench;

    localparam int CNT_W = 4;
    localparam int TH_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw_reset = 1'b0;
    logic             mode_sel = 1'b0;
    logic [TH_W-1:0]  thresh = '0;
    logic             byte_rx = 1'b0;
    logic [CNT_W-1:0] q_count = '0;
    logic             rearm_wr = 1'b0;
    logic             irq_clr = 1'b0;
    logic             irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hdlc_rx_irq_gen #(.CNT_W(CNT_W), .TH_W(TH_W)) u_hdlc_rx_irq_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_reset (sw_reset),
        .mode_sel (mode_sel),
        .thresh   (thresh),
        .byte_rx  (byte_rx),
        .q_count  (q_count),
        .rearm_wr (rearm_wr),
        .irq_clr  (irq_clr),
        .irq      (irq)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    // one-cycle strobes: set, tick, clear
    task automatic pulse(input logic b, input logic r, input logic c, input logic s);
        byte_rx = b; rearm_wr = r; irq_clr = c; sw_reset = s;
        tick();
        byte_rx = 0; rearm_wr = 0; irq_clr = 0; sw_reset = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(1'b0, "R1 reset state");
        rst_n = 1'b1;
        tick();
        check(1'b0, "R1 idle after reset");

        // first-character mode
        mode_sel = 0;
        pulse(1, 0, 0, 0); check(1'b1, "R1/R2 first byte fires");
        tick();            check(1'b1, "R8 flag sticky");
        pulse(0, 0, 1, 0); check(1'b0, "R8 clear");
        pulse(1, 0, 0, 0); check(1'b0, "R3 disarmed byte ignored");
        pulse(1, 1, 0, 0); check(1'b0, "R4 rearm with byte no fire");
        pulse(1, 0, 0, 0); check(1'b1, "R4 byte after rearm fires");
        pulse(0, 0, 1, 0); check(1'b0, "R8 clear");
        pulse(0, 1, 0, 0); check(1'b0, "R4 rearm alone");
        pulse(1, 0, 1, 0); check(1'b1, "R9 byte and clear same cycle");
        pulse(0, 0, 1, 0); check(1'b0, "R9 later clear");
        pulse(0, 0, 0, 1); check(1'b0, "R5 sw_reset");
        pulse(1, 0, 0, 0); check(1'b1, "R5 armed after sw_reset");
        pulse(1, 0, 0, 1); check(1'b0, "R5 sw_reset beats byte");
        pulse(1, 0, 0, 0); check(1'b1, "R5 still armed after sw_reset with byte");

        // mode gating
        pulse(0, 0, 0, 1);
        mode_sel = 1; q_count = 0; thresh = 7;
        pulse(1, 0, 0, 0); check(1'b0, "R10 byte in threshold mode");
        mode_sel = 0;
        pulse(1, 0, 0, 0); check(1'b1, "R10 armed state kept");
        pulse(0, 0, 0, 1);
        thresh = 2; q_count = 9;
        tick();            check(1'b0, "R10 crossing in first-char mode");
        q_count = 0;
        tick();

        // threshold sweep
        mode_sel = 1;
        for (int t = 0; t < 8; t++) begin
            for (int c = 0; c < 16; c++) begin
                logic ov;
                ov = (c > t);
                thresh = t[TH_W-1:0]; q_count = 0;
                pulse(0, 0, 0, 1);
                q_count = c[CNT_W-1:0];
                tick();            check(ov, "R6 crossing");
                pulse(0, 0, 1, 0); check(1'b0, "R7 cleared");
                tick();            check(ov, "R7 refire while above");
            end
        end

        // crossing coincident with clear
        thresh = 3; q_count = 0;
        pulse(0, 0, 0, 1);
        q_count = 4;
        pulse(0, 0, 1, 0); check(1'b1, "R9 crossing and clear same cycle");
        q_count = 3;
        pulse(0, 0, 1, 0); check(1'b0, "R8 clear after fall");
        tick();            check(1'b0, "R6 equal does not fire");
        q_count = 5;
        tick();            check(1'b1, "R6 recross fires");
        pulse(1, 1, 0, 1); check(1'b0, "R5 sw_reset beats rearm");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule